// File: doc/BRIEF.md
# Two-Counter PWM Tone Generator

This block produces a pulse-width-modulated square wave for the input pin of an audio amplifier. Two down-counters build each period. The first counter sets the length of the period. The second counter sets how long the output stays high at the start of that period. Each length is the value the host loads plus two clock cycles. The host loads the period value, the high-time value and an enable flag through a plain write port made of an address, a data word and a write strobe.

The load values the host writes are staged in holding registers. The counters take them only at a period boundary, so a write made while the wave is running never cuts a period short and never produces a stray pulse. Clearing the enable flag forces the pin low and holds both counters at their reload values. Setting the flag again starts a fresh period on the next cycle.

Top module: `pwm_pair_timer`

## Requirements
- R1: After reset the output is low, the enable flag is clear and both load registers hold zero. Enabling straight after reset therefore gives an output that stays high all the time.
- R2: While the enable flag is clear, the output is low. A write that clears the flag drives the output low from the next cycle and reloads both counters.
- R3: With the enable flag set, the output repeats with a period of exactly (period load + 2) clock cycles.
- R4: When (high load + 2) is smaller than the period, the output is high for exactly (high load + 2) cycles of each period and low for the rest.
- R5: When the high load is greater than or equal to the period load, the output stays high for the whole of every period.
- R6: A load written while the output is running has no effect on the period in progress. It takes effect from the first period that starts after the write.
- R7: The output is high in the first cycle after the write that sets the enable flag, and in the first cycle of every period.
- R8: Register map, by write address. Address 0 holds the enable flag in bit 0, and its other bits are ignored. Address 1 holds the period load. Address 2 holds the high load. Writes to address 3 change nothing.
- R9: The largest load value of the full width works without wrap-around. A period load of all ones gives a period of 2^LOAD_W + 1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe, one cycle per write |
| wrAddr | input | ADDR_W | Register address for the write |
| wrData | input | LOAD_W | Write data |
| pwmOut | output | 1 | PWM output to the amplifier |

## Verification
The bench builds the block with LOAD_W = 8. With this width, every pairing of period loads 0 to 6 with high loads 0 to 8 is compared cycle by cycle against the formula, so the cases with the high time shorter than, equal to and longer than the period are all covered. The narrow width also makes the all-ones period load short enough to run. That run shows that the counter holds the load-plus-two value without wrapping. Writes made in the middle of a period check the staging of new loads, the ignored address and the ignored upper control bits.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  // Register addresses; the block decodes these on every write.
  localparam int ADDR_CTRL   = 0;
  localparam int ADDR_PERIOD = 1;
  localparam int ADDR_HIGH   = 2;

  // Strobes from the control to the counter datapath.
  typedef struct packed {
    logic reload;      // load both counters from the holding registers
    logic stepPeriod;  // decrement the period counter
    logic stepHigh;    // decrement the high-time counter
    logic endHigh;     // high time has run out: drop the output
  } strobe_t;

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs #(
  parameter int LOAD_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [LOAD_W-1:0] wrData,
  output logic              enable,
  output logic [LOAD_W-1:0] loadPeriod,
  output logic [LOAD_W-1:0] loadHigh
);
  import pwm_pkg::*;

  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(ADDR_CTRL);
  localparam logic [ADDR_W-1:0] A_PERIOD = ADDR_W'(ADDR_PERIOD);
  localparam logic [ADDR_W-1:0] A_HIGH   = ADDR_W'(ADDR_HIGH);

  logic hitCtrl, hitPeriod, hitHigh;

  always_comb begin
    hitCtrl   = wrEn && (wrAddr == A_CTRL);
    hitPeriod = wrEn && (wrAddr == A_PERIOD);
    hitHigh   = wrEn && (wrAddr == A_HIGH);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enable     <= 1'b0;
      loadPeriod <= '0;
      loadHigh   <= '0;
    end else begin
      if (hitCtrl)   enable     <= wrData[0];
      if (hitPeriod) loadPeriod <= wrData;
      if (hitHigh)   loadHigh   <= wrData;
    end
  end

  // R8: a write to any unmapped address leaves every register unchanged
  p_unmapped_ignored_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !hitCtrl && !hitPeriod && !hitHigh) |=>
      ($stable(enable) && $stable(loadPeriod) && $stable(loadHigh)));

  // R8: a period write lands exactly the written word
  p_period_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    hitPeriod |=> (loadPeriod == $past(wrData)));

endmodule

// File: rtl/pwm_datapath.sv
module pwm_datapath #(
  parameter int LOAD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  pwm_pkg::strobe_t  strb,
  input  logic [LOAD_W-1:0] loadPeriod,
  input  logic [LOAD_W-1:0] loadHigh,
  output logic              periodZero,
  output logic              highZero,
  output logic              highLive
);
  // One extra bit so that an all-ones load plus one still fits.
  localparam int CNT_W = LOAD_W + 1;

  logic [CNT_W-1:0] pCnt, hCnt;
  logic [CNT_W-1:0] pStart, hStart;

  // Counting from load+1 down to zero spans load+2 cycles.
  always_comb begin
    pStart = {1'b0, loadPeriod} + CNT_W'(1);
    hStart = {1'b0, loadHigh}   + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pCnt     <= CNT_W'(1);
      hCnt     <= CNT_W'(1);
      highLive <= 1'b1;
    end else if (strb.reload) begin
      pCnt     <= pStart;
      hCnt     <= hStart;
      highLive <= 1'b1;
    end else begin
      if (strb.stepPeriod) pCnt <= pCnt - CNT_W'(1);
      if (strb.stepHigh)   hCnt <= hCnt - CNT_W'(1);
      if (strb.endHigh)    highLive <= 1'b0;
    end
  end

  always_comb begin
    periodZero = (pCnt == '0);
    highZero   = (hCnt == '0);
  end

  // R2/R6: a reload takes the value held in the load register at that edge
  p_reload_takes_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.reload |=> (pCnt == {1'b0, $past(loadPeriod)} + CNT_W'(1)));

  // R3: between boundaries the period counter falls by exactly one
  p_period_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.stepPeriod |=> (pCnt == $past(pCnt) - CNT_W'(1)));

  // R7: every new period opens with the output level high
  p_high_rise_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.reload |=> highLive);

  // R4: once dropped, the high level stays down until the next reload
  p_low_holds_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!highLive && !strb.reload) |=> !highLive);

endmodule

// File: rtl/pwm_ctrl.sv
module pwm_ctrl (
  input  logic             enable,
  input  logic             periodZero,
  input  logic             highZero,
  input  logic             highLive,
  output pwm_pkg::strobe_t strb,
  output logic             pwmOut
);

  logic running;

  always_comb begin
    running         = enable && !periodZero;
    // Idle or at the last cycle of a period: load the next period.
    strb.reload     = !enable || periodZero;
    strb.stepPeriod = running;
    strb.stepHigh   = running && !highZero;
    strb.endHigh    = running && highZero;
    pwmOut          = enable && highLive;
  end

  // R5/R2: the strobes never ask for a reload and a step together
  always_comb begin
    p_strobe_excl_r5: assert ($onehot0({strb.reload, strb.stepPeriod}));
  end

endmodule

// File: rtl/pwm_pair_timer.sv
module pwm_pair_timer #(
  parameter int LOAD_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [LOAD_W-1:0] wrData,
  output logic              pwmOut
);
  import pwm_pkg::*;

  logic              enable;
  logic [LOAD_W-1:0] loadPeriod, loadHigh;
  logic              periodZero, highZero, highLive;
  strobe_t           strb;

  pwm_regs #(.LOAD_W(LOAD_W), .ADDR_W(ADDR_W)) i_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .enable(enable), .loadPeriod(loadPeriod), .loadHigh(loadHigh)
  );

  pwm_datapath #(.LOAD_W(LOAD_W)) i_datapath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .loadPeriod(loadPeriod), .loadHigh(loadHigh),
    .periodZero(periodZero), .highZero(highZero), .highLive(highLive)
  );

  pwm_ctrl i_ctrl (
    .enable(enable), .periodZero(periodZero), .highZero(highZero),
    .highLive(highLive), .strb(strb), .pwmOut(pwmOut)
  );

  // R2: in the cycle after the flag is cleared the pin is low
  p_disable_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(enable) |-> !pwmOut);

  // R7: in the cycle after the flag is set the pin is high
  p_enable_high_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(enable) |-> pwmOut);

endmodule

// File: tb/test_pwm_pair_timer.sv
module test_pwm_pair_timer;
  localparam int LW = 8;
  localparam int AW = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [LW-1:0] wrData = '0;
  logic          pwmOut;

  int  errors = 0;
  int  checks = 0;
  bit  done = 0;

  always #5 clk = ~clk;

  pwm_pair_timer #(.LOAD_W(LW), .ADDR_W(AW)) i_pwm_pair_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .pwmOut(pwmOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Write one register; returns at the negedge right after the write edge.
  task automatic wr(input int a, input int d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = AW'(a); wrData = LW'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  function automatic bit expLevel(input int i, input int l0, input int l1);
    int p = l0 + 2;
    int h = (l1 + 2 < p) ? l1 + 2 : p;
    return (i % p) < h;
  endfunction

  // Waveform check; cycle 0 is the cycle after the enabling write.
  // Phase A (la0,la1) for swPer periods, then phase B (lb0,lb1).
  // Two optional writes are injected at cycles injAt and injAt+1.
  task automatic runWave(input int la0, input int la1, input int lb0, input int lb1,
                         input int swPer, input int cycles, input int injAt,
                         input int a1, input int d1, input int a2, input int d2,
                         input string req);
    int bad = 0;
    int firstAct = 0;
    int firstExp = 0;
    for (int i = 0; i < cycles; i++) begin
      bit e;
      int edgeA = swPer * (la0 + 2);
      if (i < edgeA) e = expLevel(i, la0, la1);
      else           e = expLevel(i - edgeA, lb0, lb1);
      if (pwmOut !== e) begin
        if (bad == 0) begin firstAct = int'(pwmOut); firstExp = int'(e); end
        bad++;
      end
      if (i == injAt) begin
        wrEn = 1'b1; wrAddr = AW'(a1); wrData = LW'(d1);
      end else if (i == injAt + 1) begin
        wrEn = 1'b1; wrAddr = AW'(a2); wrData = LW'(d2);
      end else begin
        wrEn = 1'b0;
      end
      @(negedge clk);
    end
    wrEn = 1'b0;
    check(bad == 0, req, firstAct, firstExp);
  endtask

  task automatic checkLow(input int n, input string req);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      if (pwmOut !== 1'b0) bad++;
      @(negedge clk);
    end
    check(bad == 0, req, bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: low after reset
    check(pwmOut === 1'b0, "R1 reset level", int'(pwmOut), 0);
    // R1 + R5: zero loads after reset, enabling gives constant high
    wr(0, 1);
    runWave(0, 0, 0, 0, 1000, 12, -5, 0, 0, 0, 0, "R1 zero loads always high");
    wr(0, 0);
    checkLow(6, "R2 low while disabled");

    // R3 R4 R5 R7: sweep of period and high loads
    for (int l0 = 0; l0 <= 6; l0++) begin
      for (int l1 = 0; l1 <= 8; l1++) begin
        wr(1, l0);
        wr(2, l1);
        wr(0, 1);
        runWave(l0, l1, l0, l1, 1000, 3 * (l0 + 2) + 2, -5, 0, 0, 0, 0,
                (l1 >= l0) ? "R5 R7 full high" : "R3 R4 R7 period/high");
        wr(0, 0);
        check(pwmOut === 1'b0, "R2 low after disable", int'(pwmOut), 0);
      end
    end

    // R6: loads rewritten mid-period take effect at the next boundary
    wr(1, 3);
    wr(2, 1);
    wr(0, 1);
    runWave(3, 1, 5, 4, 1, 5 + 3 * 7, 1, 1, 5, 2, 4, "R6 staged update");
    wr(0, 0);
    checkLow(4, "R2 low after R6 run");

    // R8: address 3 and upper control bits change nothing
    wr(1, 2);
    wr(2, 0);
    wr(0, 1);
    runWave(2, 0, 2, 0, 1000, 24, 2, 3, 255, 0, 3, "R8 ignored writes");
    wr(0, 0);
    // R8: control write with bit 0 clear but upper bits set disables
    wr(0, 1);
    wr(0, 254);
    checkLow(5, "R8 bit0 clear disables");

    // R9: all-ones period load, period 257 and high 256
    wr(1, 255);
    wr(2, 254);
    wr(0, 1);
    runWave(255, 254, 255, 254, 1000, 2 * 257 + 4, -5, 0, 0, 0, 0, "R9 full width");
    wr(0, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule